// File: doc/BRIEF.md
# Comma-Aligned Two-Character Word Deserializer

This block takes a recovered serial bit stream, one bit per clock on which a bit-rate enable is high, and rebuilds 20-bit parallel words. Each word holds two 10-bit code words. The first code word received goes in bits [9:0], and the first bit received within a word goes in bit 0.

The block watches every bit position for the 8b/10b K28.5 comma, in either running-disparity form. While alignment is allowed, it moves the word boundary so that the comma sits in the lower code word of the next word it issues. A comma that turns up in the upper code word moves the boundary by exactly one code word. Clock recovery and 8b/10b decoding are done outside the block.

Top module: `comma_deser`

## Requirements
- R1: While reset is held and after it is released, `word_vld`, `comma_hit` and `locked` are 0 and `word_out` is all zeros until the first word is issued.
- R2: Bit k of an issued word, for k from 0 to 19, is the k-th bit received for that word. Bits [9:0] therefore hold the earlier code word and bits [19:10] hold the later one.
- R3: `word_vld` is a one-clock pulse in the cycle after the enabled edge that takes in the 20th bit of a word. When there is no realignment, consecutive pulses are exactly 20 enabled bits apart, however many idle clocks are inserted. `word_vld` is never raised, and `word_out` never changes, after an edge where `bit_en` is low.
- R4: A comma is the last 10 received bits, in arrival order, matching either 0011111010 or 1100000101. As a 10-bit value with the first bit in bit 0, these are 0x17C and 0x283. `comma_hit` pulses for one clock after the edge that takes in the comma's last bit. A comma is recognised only once at least 10 bits have arrived since reset.
- R5: When a comma is recognised while `align_en` is high, the comma's last bit becomes position 9 of the current word. The next word issued, 10 enabled bits later, carries the comma in bits [9:0]. Every issued word consists only of bits actually received.
- R6: A comma recognised in the upper code word while `align_en` is high moves the boundary by one code word. The word that would have carried it in its upper half is not issued.
- R7: While `align_en` is low, a comma still raises `comma_hit`, but the boundary and `locked` are left unchanged.
- R8: `locked` rises one clock after a comma is recognised with `align_en` high. It then stays set until reset, or until `align_en` is seen high one clock after being seen low. A comma recognised on that same edge keeps `locked` set.
- R9: Whatever the bit offset (0 to 19) at which a comma arrives, `locked` is set after that single comma and the following word carries it in bits [9:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | High on clocks that carry a valid serial bit |
| bit_in | input | 1 | Serial data bit |
| align_en | input | 1 | Allows comma-driven realignment of the boundary |
| word_out | output | 20 | Last issued two-character word |
| word_vld | output | 1 | One-clock strobe for a new `word_out` |
| comma_hit | output | 1 | One-clock pulse when a comma is recognised |
| locked | output | 1 | A comma has set the boundary since the last re-enable |

## Verification
All three outputs respond one clock after the enabled edge that takes in the deciding bit. `comma_hit` and `locked` respond to a comma's last bit. `word_vld` and `word_out` respond to a word's 20th bit, which after an aligning comma falls 10 enabled bits later. The bench drives each input at a falling edge and steps a queue-based model with the same bit. It then compares every output at the next falling edge, after exactly one rising edge, so that each expectation lands in the cycle the requirement names. Idle clocks are interleaved with the bits so that the strobe spacing is measured in enabled bits, not in clocks.

// File: rtl/comma_deser_pkg.sv
package comma_deser_pkg;

  localparam int CODE_BITS_DEF = 10;
  localparam int NUM_CODES_DEF = 2;

  // K28.5, negative disparity, first received bit in bit 0
  localparam logic [9:0] K28P5_FIRST_LSB = 10'h17C;

  function automatic int word_bits(input int code_bits, input int num_codes);
    return code_bits * num_codes;
  endfunction

  // Next bit position inside a word, wrapping after the last one
  function automatic int wrap_next(input int pos, input int last);
    return (pos == last) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/cd_bit_history.sv
module cd_bit_history
  import comma_deser_pkg::*;
#(
  parameter int WW        = 20,
  parameter int CODE_BITS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          bit_in,
  output logic [WW-1:0] hist_next,
  output logic          primed
);
  localparam int FILL_W = $clog2(CODE_BITS);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(CODE_BITS - 1);

  logic [WW-1:0]     hist_q;
  logic [FILL_W-1:0] fill_q;

  // newest bit enters at the top, oldest sits in bit 0
  assign hist_next = {bit_in, hist_q[WW-1:1]};
  assign primed    = (fill_q == FILL_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (bit_en) begin
      hist_q <= hist_next;
      if (fill_q != FILL_MAX) fill_q <= fill_q + FILL_W'(1);
    end
  end
endmodule

// File: rtl/cd_comma_find.sv
module cd_comma_find
  import comma_deser_pkg::*;
#(
  parameter int                   CODE_BITS = 10,
  parameter logic [CODE_BITS-1:0] COMMA_PAT = CODE_BITS'(K28P5_FIRST_LSB)
) (
  input  logic [CODE_BITS-1:0] code,
  output logic                 hit
);
  logic [1:0] pol_match;

  for (genvar p = 0; p < 2; p++) begin : g_pol
    localparam logic [CODE_BITS-1:0] PAT = (p == 0) ? COMMA_PAT : ~COMMA_PAT;
    assign pol_match[p] = (code == PAT);
  end

  assign hit = |pol_match;
endmodule

// File: rtl/cd_boundary.sv
module cd_boundary
  import comma_deser_pkg::*;
#(
  parameter int WW        = 20,
  parameter int CODE_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic align_en,
  input  logic comma_seen,
  output logic word_done,
  output logic realign,
  output logic locked
);
  localparam int POS_W = $clog2(WW);
  localparam logic [POS_W-1:0] LOW_END = POS_W'(CODE_BITS - 1);
  localparam logic [POS_W-1:0] LAST    = POS_W'(WW - 1);
  localparam logic [POS_W-1:0] RESTART = POS_W'(CODE_BITS);

  logic [POS_W-1:0] pos_q;
  logic             align_q;
  logic             lock_q;
  logic             lock_set;
  logic             lock_clr;

  assign realign   = bit_en & comma_seen & align_en & (pos_q != LOW_END);
  assign word_done = bit_en & ~realign & (pos_q == LAST);
  assign lock_set  = bit_en & comma_seen & align_en;
  assign lock_clr  = align_en & ~align_q;
  assign locked    = lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      align_q <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      align_q <= align_en;
      if (lock_set)      lock_q <= 1'b1;
      else if (lock_clr) lock_q <= 1'b0;
      if (bit_en)
        pos_q <= realign ? RESTART : POS_W'(wrap_next(int'(pos_q), WW - 1));
    end
  end
endmodule

// File: rtl/cd_word_reg.sv
module cd_word_reg #(
  parameter int WW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_done,
  input  logic          comma_tick,
  input  logic [WW-1:0] word_in,
  output logic [WW-1:0] word_out,
  output logic          word_vld,
  output logic          comma_hit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_out  <= '0;
      word_vld  <= 1'b0;
      comma_hit <= 1'b0;
    end else begin
      word_vld  <= word_done;
      comma_hit <= comma_tick;
      if (word_done) word_out <= word_in;
    end
  end
endmodule

// File: rtl/comma_deser.sv
module comma_deser
  import comma_deser_pkg::*;
#(
  parameter int                   CODE_BITS = CODE_BITS_DEF,
  parameter int                   NUM_CODES = NUM_CODES_DEF,
  parameter logic [CODE_BITS-1:0] COMMA_PAT = CODE_BITS'(K28P5_FIRST_LSB)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bit_en,
  input  logic                           bit_in,
  input  logic                           align_en,
  output logic [CODE_BITS*NUM_CODES-1:0] word_out,
  output logic                           word_vld,
  output logic                           comma_hit,
  output logic                           locked
);
  localparam int WW = word_bits(CODE_BITS, NUM_CODES);

  logic [WW-1:0] hist_next;
  logic          primed;
  logic          raw_hit;
  logic          comma_ev;
  logic          comma_tick;
  logic          realign_ev;
  logic          word_done_ev;

  cd_bit_history #(.WW(WW), .CODE_BITS(CODE_BITS)) u_hist (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .hist_next(hist_next), .primed(primed)
  );

  // the newest CODE_BITS bits, oldest in the lowest position
  cd_comma_find #(.CODE_BITS(CODE_BITS), .COMMA_PAT(COMMA_PAT)) u_find (
    .code(hist_next[WW-1 -: CODE_BITS]), .hit(raw_hit)
  );

  assign comma_ev   = raw_hit & primed;
  assign comma_tick = bit_en & comma_ev;

  cd_boundary #(.WW(WW), .CODE_BITS(CODE_BITS)) u_bound (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .align_en(align_en),
    .comma_seen(comma_ev), .word_done(word_done_ev), .realign(realign_ev),
    .locked(locked)
  );

  cd_word_reg #(.WW(WW)) u_out (
    .clk(clk), .rst_n(rst_n), .word_done(word_done_ev), .comma_tick(comma_tick),
    .word_in(hist_next), .word_out(word_out), .word_vld(word_vld),
    .comma_hit(comma_hit)
  );
endmodule

// File: rtl/comma_deser_chk.sv
module comma_deser_chk #(
  parameter int WW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          align_en,
  input logic [WW-1:0] word_out,
  input logic          word_vld,
  input logic          comma_hit,
  input logic          locked,
  input logic          comma_ev,
  input logic          realign_ev
);
  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);

  // R3
  strobe_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> !word_vld);

  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(word_out));

  // R4
  comma_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && comma_ev) |=> comma_hit);

  // R6
  realign_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    realign_ev |=> !word_vld);

  // R8
  lock_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && comma_ev && align_en) |=> locked);

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !align_en) |=> locked);
endmodule

bind comma_deser comma_deser_chk #(.WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .align_en(align_en),
  .word_out(word_out), .word_vld(word_vld), .comma_hit(comma_hit),
  .locked(locked), .comma_ev(comma_ev), .realign_ev(realign_ev)
);

// File: tb/tb_comma_deser.sv
module tb_comma_deser;
  localparam logic [9:0]  CNEG = 10'h17C;
  localparam logic [9:0]  CPOS = 10'h283;
  localparam logic [19:0] D0   = 20'h5A69A;
  localparam logic [19:0] D1   = 20'h96A56;

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, bit_in = 1'b0, align_en = 1'b0;
  logic [19:0] word_out;
  logic word_vld, comma_hit, locked;

  always #5 clk = ~clk;

  comma_deser dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .align_en(align_en), .word_out(word_out), .word_vld(word_vld),
    .comma_hit(comma_hit), .locked(locked)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  bit hist[$];
  int start = 0;
  bit m_lk = 0, m_prev_al = 0;
  bit e_vld, e_comma;
  logic [19:0] e_word;

  // observation helpers
  bit got_vld = 0;
  logic [19:0] got_word = '0;
  int vld_count = 0, ens = 0, last_vld_ens = -1;
  bit gap_meas = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit en, input bit b, input bit al);
    int n;
    logic [9:0] ten;
    bit is_c;
    e_vld = 0; e_comma = 0; is_c = 0; ten = '0;
    if (al && !m_prev_al) m_lk = 0;
    if (en) begin
      hist.push_back(b);
      n = hist.size() - 1;
      if (n >= 9) begin
        for (int i = 0; i < 10; i++) ten[i] = hist[n-9+i];
        is_c = (ten == CNEG) || (ten == CPOS);
      end
      if (is_c) e_comma = 1;
      if (is_c && al) m_lk = 1;
      if (is_c && al && (n - start) != 9) start = n - 9;
      else if (n - start == 19) begin
        e_vld = 1;
        for (int i = 0; i < 20; i++) e_word[i] = hist[start+i];
        start = n + 1;
      end
    end
    m_prev_al = al;
    bit_en = en; bit_in = b; align_en = al;
    @(negedge clk);
    chk(word_vld == e_vld, "R3", "word_vld", 20'(word_vld), 20'(e_vld));
    chk(comma_hit == e_comma, "R4", "comma_hit", 20'(comma_hit), 20'(e_comma));
    chk(locked == m_lk, "R8", "locked", 20'(locked), 20'(m_lk));
    if (e_vld) chk(word_out == e_word, "R5", "word_out", word_out, e_word);
    if (en) ens++;
    if (word_vld) begin
      got_vld = 1; got_word = word_out; vld_count++;
      if (gap_meas) begin
        if (last_vld_ens >= 0)
          chk(ens - last_vld_ens == 20, "R3", "enabled bits between strobes",
              20'(ens - last_vld_ens), 20'd20);
        last_vld_ens = ens;
      end
    end
  endtask

  task automatic send10(input logic [9:0] v, input bit al, input int gap);
    for (int i = 0; i < 10; i++) begin
      step(1, v[i], al);
      repeat (gap) step(0, 0, al);
    end
  endtask

  task automatic send20(input logic [19:0] v, input bit al, input int gap);
    send10(v[9:0], al, gap);
    send10(v[19:10], al, gap);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!word_vld && !comma_hit && !locked && word_out == '0, "R1", "outputs in reset",
        {word_out[16:0], word_vld, comma_hit, locked}, 20'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!word_vld && !comma_hit && !locked && word_out == '0, "R1", "outputs after reset",
        {word_out[16:0], word_vld, comma_hit, locked}, 20'd0);

    // R2: plain word, alignment off
    got_vld = 0;
    send20(D0, 0, 0);
    chk(got_vld && got_word == D0, "R2", "bit order of first word", got_word, D0);

    // R9: comma at every offset, alternate polarities
    for (int off = 0; off < 20; off++) begin
      logic [9:0] cv;
      cv = (off % 2) ? CPOS : CNEG;
      step(0, 0, 0);
      step(0, 0, 1);
      chk(locked == 0, "R8", "lock cleared on re-enable", 20'(locked), 20'd0);
      for (int i = 0; i < off; i++) step(1, i[0], 1);
      send10(cv, 1, 0);
      chk(locked == 1, "R9", "lock after one comma", 20'(locked), 20'd1);
      got_vld = 0;
      send10(D0[9:0], 1, 0);
      chk(got_vld && got_word[9:0] == cv, "R9", "comma in lower half",
          20'(got_word[9:0]), 20'(cv));
      send20(D1, 1, 0);
    end

    // R6: comma lands in the upper half of an aligned word
    send10(D0[9:0], 1, 0);
    vld_count = 0;
    send10(CNEG, 1, 0);
    chk(vld_count == 0, "R6", "word with upper comma dropped", 20'(vld_count), 20'd0);
    got_vld = 0;
    send10(D1[9:0], 1, 0);
    chk(got_vld && got_word[9:0] == CNEG, "R6", "shifted by one code word",
        20'(got_word[9:0]), 20'(CNEG));
    send20(D0, 1, 0);

    // R7: alignment disabled, misplaced comma
    step(0, 0, 0);
    for (int i = 0; i < 5; i++) step(1, i[0], 0);
    send10(CPOS, 0, 0);
    chk(comma_hit == 1, "R7", "comma still flagged", 20'(comma_hit), 20'd1);
    chk(locked == 1, "R7", "lock unchanged", 20'(locked), 20'd1);
    got_vld = 0;
    for (int i = 0; i < 5; i++) step(1, i[0], 0);
    chk(got_vld && got_word[9:0] != CPOS, "R7", "boundary held",
        20'(got_word[9:0]), 20'(CPOS));
    send20(D1, 0, 0);

    // R8: re-enable clears lock
    step(0, 0, 1);
    chk(locked == 0, "R8", "lock cleared", 20'(locked), 20'd0);

    // R3: strobe spacing with idle clocks in between
    send10(CNEG, 1, 1);
    chk(locked == 1, "R8", "lock set again", 20'(locked), 20'd1);
    gap_meas = 1; last_vld_ens = -1;
    send20(D0, 1, 1);
    send20(D1, 1, 2);
    send20(D0, 1, 0);
    gap_meas = 0;
    repeat (3) step(0, 0, 1);

    finish_run();
  end
endmodule